// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block turns the outputs of three supply comparators into processor control. The comparators report whether the supply is below a warning level, below the minimum operating level, or below the backup-cell level. The block synchronises each flag and acts on it only once it has stayed steady. A drop below the warning level raises a one-cycle interrupt request that carries a fixed vector, and execution is not disturbed. A drop below the minimum level holds the processor in reset and forces every memory chip enable and the write strobe to their inactive high level. It also pulls an open-drain reset-status pin low. A drop below the backup-cell level asserts an active-low backup-active output.

The reset-status pin works in both directions. Any low seen on it, including one driven by another device on the same net, also forces reset, so several supervisors can enter and leave power-down reset together. An active-high external reset input is a third reset source. Once every reset source has cleared, reset stays asserted for a fixed power-on delay, 21,504 clocks by default, before it is released.

Top module: `supply_supervisor`

## Requirements
- R1: A comparator, external-reset or status-pin input is acted on only after its synchronised value has differed from the accepted value for SETTLE_CYCLES consecutive clocks (default 4). A pulse shorter than that has no effect.
- R2: When irq_en is 1 and the accepted below-warning flag goes from 0 to 1, pfw_irq is high for exactly one clock. In that clock irq_vector equals IRQ_VECTOR (default 8'h2B). In every other clock irq_vector is 0.
- R3: When irq_en is 0, a crossing below the warning level raises no pfw_irq.
- R4: pfw_irq is never raised in the clock after one in which cpu_reset is high.
- R5: While the accepted below-minimum flag is 1, cpu_reset is 1, and every bit of mem_en_n_out and wr_n_out is 1. In all other cases mem_en_n_out and wr_n_out follow mem_en_n_in and wr_n_in one clock later.
- R6: stat_pull_low is 1 (the status pin is driven low) exactly while the accepted below-minimum flag is 1.
- R7: backup_act_n is 0 while the accepted below-backup flag is 1, and 1 otherwise.
- R8: A low level on stat_pin_in, from any driver, forces cpu_reset to 1.
- R9: A high level on ext_reset forces cpu_reset to 1.
- R10: After the last reset source clears, cpu_reset stays 1 for POR_CYCLES clocks (default 21504) and then falls to 0.
- R11: After the synchronous rst, cpu_reset and stat_pull_low are 1, mem_en_n_out and wr_n_out are all ones, backup_act_n is 1 and pfw_irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| below_warn | input | 1 | Asynchronous comparator flag: supply below the warning level |
| below_min | input | 1 | Asynchronous comparator flag: supply below the minimum level |
| below_bak | input | 1 | Asynchronous comparator flag: supply below the backup-cell level |
| ext_reset | input | 1 | Active-high external reset request |
| stat_pin_in | input | 1 | Level read back from the open-drain reset-status pin |
| irq_en | input | 1 | Enables the power-fail warning interrupt |
| mem_en_n_in | input | NUM_EN | Active-low memory chip enables from the bus controller |
| wr_n_in | input | 1 | Active-low write strobe from the bus controller |
| cpu_reset | output | 1 | Processor reset, active high |
| pfw_irq | output | 1 | Single-cycle power-fail warning interrupt request |
| irq_vector | output | 8 | Interrupt vector, valid while pfw_irq is 1 |
| mem_en_n_out | output | NUM_EN | Gated active-low memory chip enables |
| wr_n_out | output | 1 | Gated active-low write strobe |
| backup_act_n | output | 1 | Active-low flag: running from the backup cell |
| stat_pull_low | output | 1 | When 1, the status pin pad is driven low |

## Verification
The bench builds the block with POR_CYCLES set to 40 instead of 21,504 and with NUM_EN set to 4. The short delay lets a single run go through many reset and release cycles and measure each release gap against both limits of R10. SYNC_STAGES and SETTLE_CYCLES keep their defaults, so a two-clock glitch is shorter than the settle window and exercises R1. The bench also closes the status-pin loop: its model of the pad combines stat_pull_low with a pull-down from another device.

// File: rtl/pss_pkg.sv
package pss_pkg;
  // indices of the filtered input sources
  localparam int SRC_WARN = 0;
  localparam int SRC_MIN  = 1;
  localparam int SRC_BAK  = 2;
  localparam int SRC_EXT  = 3;
  localparam int SRC_PAD  = 4;
  localparam int NUM_SRC  = 5;
  // values the filters take in reset: assume the supply is low
  localparam logic [NUM_SRC-1:0] SRC_RST_VAL = 5'b00011;
endpackage

// File: rtl/pss_filter.sv
module pss_filter #(
  parameter int   SYNC_STAGES   = 2,
  parameter int   SETTLE_CYCLES = 4,
  parameter logic RST_VAL       = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CW = $clog2(SETTLE_CYCLES + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;
  logic                   sync_msb;

  assign sync_msb = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) sync_q <= {SYNC_STAGES{RST_VAL}};
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      filt_o <= RST_VAL;
    end else if (sync_msb == filt_o) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(SETTLE_CYCLES - 1)) begin
      cnt_q  <= '0;
      filt_o <= sync_msb;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R1: an accepted change must have been present on the synchroniser two clocks before
  a_r1_settle: assert property (@(posedge clk) disable iff (rst)
    !$stable(filt_o) |-> ($past(sync_msb, 2) == filt_o));
endmodule

// File: rtl/pss_por_timer.sv
module pss_por_timer #(
  parameter int POR_CYCLES = 21504
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_i,
  output logic reset_o
);
  localparam int CW = $clog2(POR_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= CW'(POR_CYCLES);
      reset_o <= 1'b1;
    end else if (hold_i) begin
      cnt_q   <= CW'(POR_CYCLES);
      reset_o <= 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q   <= cnt_q - 1'b1;
      reset_o <= 1'b1;
    end else begin
      reset_o <= 1'b0;
    end
  end

  // R10: reset is still held when the last source drops
  a_r10_hold_on_release: assert property (@(posedge clk) disable iff (rst)
    $fell(hold_i) |-> reset_o);
  // R10: reset only falls once the countdown has run out
  a_r10_release_at_zero: assert property (@(posedge clk) disable iff (rst)
    $fell(reset_o) |-> ($past(cnt_q) == '0));
endmodule

// File: rtl/pss_out_gate.sv
module pss_out_gate #(
  parameter int         NUM_EN     = 8,
  parameter logic [7:0] IRQ_VECTOR = 8'h2B
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              warn_i,
  input  logic              min_i,
  input  logic              bak_i,
  input  logic              cpu_reset_i,
  input  logic              irq_en_i,
  input  logic [NUM_EN-1:0] mem_en_n_i,
  input  logic              wr_n_i,
  output logic [NUM_EN-1:0] mem_en_n_o,
  output logic              wr_n_o,
  output logic              bak_n_o,
  output logic              stat_oe_o,
  output logic              irq_o,
  output logic [7:0]        irq_vec_o
);
  logic warn_prev_q;
  logic irq_fire;

  assign irq_fire = warn_i && !warn_prev_q && irq_en_i && !cpu_reset_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_en_n_o  <= '1;
      wr_n_o      <= 1'b1;
      bak_n_o     <= 1'b1;
      stat_oe_o   <= 1'b1;
      irq_o       <= 1'b0;
      irq_vec_o   <= '0;
      warn_prev_q <= 1'b1;
    end else begin
      mem_en_n_o  <= min_i ? '1 : mem_en_n_i;
      wr_n_o      <= min_i | wr_n_i;
      bak_n_o     <= ~bak_i;
      stat_oe_o   <= min_i;
      irq_o       <= irq_fire;
      irq_vec_o   <= irq_fire ? IRQ_VECTOR : 8'h00;
      warn_prev_q <= warn_i;
    end
  end

  a_r5_enables_forced: assert property (@(posedge clk) disable iff (rst)
    min_i |=> ((&mem_en_n_o) && wr_n_o));
  a_r6_status_drive: assert property (@(posedge clk) disable iff (rst)
    min_i |=> stat_oe_o);
  a_r7_backup_flag: assert property (@(posedge clk) disable iff (rst)
    bak_i |=> !bak_n_o);
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);
  a_r3_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    !irq_en_i |=> !irq_o);
  a_r4_blocked_in_reset: assert property (@(posedge clk) disable iff (rst)
    cpu_reset_i |=> !irq_o);
endmodule

// File: rtl/supply_supervisor.sv
module supply_supervisor #(
  parameter int         NUM_EN        = 8,
  parameter int         SYNC_STAGES   = 2,
  parameter int         SETTLE_CYCLES = 4,
  parameter int         POR_CYCLES    = 21504,
  parameter logic [7:0] IRQ_VECTOR    = 8'h2B
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              below_warn,
  input  logic              below_min,
  input  logic              below_bak,
  input  logic              ext_reset,
  input  logic              stat_pin_in,
  input  logic              irq_en,
  input  logic [NUM_EN-1:0] mem_en_n_in,
  input  logic              wr_n_in,
  output logic              cpu_reset,
  output logic              pfw_irq,
  output logic [7:0]        irq_vector,
  output logic [NUM_EN-1:0] mem_en_n_out,
  output logic              wr_n_out,
  output logic              backup_act_n,
  output logic              stat_pull_low
);
  import pss_pkg::*;

  logic [NUM_SRC-1:0] raw_src;
  logic [NUM_SRC-1:0] filt_src;
  logic               hold_any;

  assign raw_src[SRC_WARN] = below_warn;
  assign raw_src[SRC_MIN]  = below_min;
  assign raw_src[SRC_BAK]  = below_bak;
  assign raw_src[SRC_EXT]  = ext_reset;
  assign raw_src[SRC_PAD]  = ~stat_pin_in;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_filt
    pss_filter #(
      .SYNC_STAGES  (SYNC_STAGES),
      .SETTLE_CYCLES(SETTLE_CYCLES),
      .RST_VAL      (SRC_RST_VAL[g])
    ) i_filt (
      .clk   (clk),
      .rst   (rst),
      .raw_i (raw_src[g]),
      .filt_o(filt_src[g])
    );
  end

  assign hold_any = filt_src[SRC_MIN] | filt_src[SRC_EXT] | filt_src[SRC_PAD];

  pss_por_timer #(.POR_CYCLES(POR_CYCLES)) i_por (
    .clk    (clk),
    .rst    (rst),
    .hold_i (hold_any),
    .reset_o(cpu_reset)
  );

  pss_out_gate #(.NUM_EN(NUM_EN), .IRQ_VECTOR(IRQ_VECTOR)) i_gate (
    .clk        (clk),
    .rst        (rst),
    .warn_i     (filt_src[SRC_WARN]),
    .min_i      (filt_src[SRC_MIN]),
    .bak_i      (filt_src[SRC_BAK]),
    .cpu_reset_i(cpu_reset),
    .irq_en_i   (irq_en),
    .mem_en_n_i (mem_en_n_in),
    .wr_n_i     (wr_n_in),
    .mem_en_n_o (mem_en_n_out),
    .wr_n_o     (wr_n_out),
    .bak_n_o    (backup_act_n),
    .stat_oe_o  (stat_pull_low),
    .irq_o      (pfw_irq),
    .irq_vec_o  (irq_vector)
  );

  a_r8_pad_forces_reset: assert property (@(posedge clk) disable iff (rst)
    filt_src[SRC_PAD] |=> cpu_reset);
  a_r9_ext_forces_reset: assert property (@(posedge clk) disable iff (rst)
    filt_src[SRC_EXT] |=> cpu_reset);
  a_r5_min_forces_reset: assert property (@(posedge clk) disable iff (rst)
    filt_src[SRC_MIN] |=> cpu_reset);
endmodule

// File: tb/test_supply_supervisor.sv
module test_supply_supervisor;
  localparam int NUM_EN = 4;
  localparam int POR    = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic below_warn = 1'b1, below_min = 1'b1, below_bak = 1'b0;
  logic ext_reset = 1'b0, ext_pull = 1'b0, irq_en = 1'b0;
  logic [NUM_EN-1:0] mem_en_n_in = '1;
  logic wr_n_in = 1'b1;
  logic stat_pin_in;
  logic cpu_reset, pfw_irq, wr_n_out, backup_act_n, stat_pull_low;
  logic [7:0] irq_vector;
  logic [NUM_EN-1:0] mem_en_n_out;

  // open-drain pad: low when this block or another device pulls it
  assign stat_pin_in = ~(stat_pull_low | ext_pull);

  supply_supervisor #(.NUM_EN(NUM_EN), .POR_CYCLES(POR)) i_supply_supervisor (
    .clk(clk), .rst(rst), .below_warn(below_warn), .below_min(below_min),
    .below_bak(below_bak), .ext_reset(ext_reset), .stat_pin_in(stat_pin_in),
    .irq_en(irq_en), .mem_en_n_in(mem_en_n_in), .wr_n_in(wr_n_in),
    .cpu_reset(cpu_reset), .pfw_irq(pfw_irq), .irq_vector(irq_vector),
    .mem_en_n_out(mem_en_n_out), .wr_n_out(wr_n_out),
    .backup_act_n(backup_act_n), .stat_pull_low(stat_pull_low));

  always #2 clk = ~clk;

  int total = 0, bad = 0, cyc = 0, mark = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {string name; string req; int gap_min; int gap_max;} ev_t;
  ev_t exp_q[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_ev(input string name, input string req, input int gmin, input int gmax);
    ev_t e;
    e.name = name; e.req = req; e.gap_min = gmin; e.gap_max = gmax;
    exp_q.push_back(e);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // monitor: pops expected events as the design produces them
  logic prev_rst = 1'b1;
  always @(negedge clk) begin
    if (!rst) begin
      string got;
      got = "";
      if (cpu_reset && !prev_rst) got = "RST_ON";
      if (!cpu_reset && prev_rst) got = "RST_OFF";
      if (got != "") pop_cmp(got);
      if (pfw_irq) begin
        pop_cmp("IRQ");
        check(irq_vector == 8'h2B, "R2 vector", irq_vector, 8'h2B);
      end else begin
        check(irq_vector == 8'h00, "R2 idle vector", irq_vector, 0);
      end
    end
    prev_rst = cpu_reset;
  end

  task automatic pop_cmp(input string got);
    ev_t e;
    if (exp_q.size() == 0) begin
      check(0, {"unexpected ", got}, 1, 0);
    end else begin
      e = exp_q.pop_front();
      check(e.name == got, {e.req, " event ", e.name, " got ", got}, 0, 0);
      if (e.gap_max > 0)
        check((cyc - mark) >= e.gap_min && (cyc - mark) <= e.gap_max,
              {e.req, " release gap"}, cyc - mark, e.gap_min);
    end
  endtask

  initial begin
    wait_cyc(3);
    // R11 reset state
    check(cpu_reset == 1, "R11 cpu_reset", cpu_reset, 1);
    check(stat_pull_low == 1, "R11 stat_pull_low", stat_pull_low, 1);
    check(mem_en_n_out == '1, "R11 mem_en_n_out", mem_en_n_out, 4'hF);
    check(wr_n_out == 1, "R11 wr_n_out", wr_n_out, 1);
    check(backup_act_n == 1 && pfw_irq == 0, "R11 backup/irq", {backup_act_n, pfw_irq}, 2);
    rst = 1'b0;
    mem_en_n_in = 4'b0101; wr_n_in = 1'b0;
    wait_cyc(5);
    check(mem_en_n_out == '1 && wr_n_out == 1, "R5 forced while low", mem_en_n_out, 4'hF);

    // supply comes up
    expect_ev("RST_OFF", "R10", POR, POR + 24);
    below_warn = 0; below_min = 0; mark = cyc;
    wait_cyc(POR + 40);
    check(cpu_reset == 0, "R10 released", cpu_reset, 0);
    check(stat_pull_low == 0, "R6 pin released", stat_pull_low, 0);
    check(mem_en_n_out == 4'b0101, "R5 enables pass", mem_en_n_out, 4'b0101);
    check(wr_n_out == 0, "R5 write passes", wr_n_out, 0);

    // R2 warning crossing with interrupt enabled
    irq_en = 1;
    expect_ev("IRQ", "R2", 0, 0);
    below_warn = 1; wait_cyc(20);
    check(cpu_reset == 0, "R2 execution continues", cpu_reset, 0);
    below_warn = 0; wait_cyc(20);
    // R1 short glitch ignored
    below_warn = 1; wait_cyc(1); below_warn = 0; wait_cyc(20);
    below_min = 1; wait_cyc(2); below_min = 0; wait_cyc(20);
    check(cpu_reset == 0, "R1 min glitch", cpu_reset, 0);
    // R3 disabled
    irq_en = 0; below_warn = 1; wait_cyc(20);
    below_warn = 0; wait_cyc(20);
    check(exp_q.size() == 0, "R3 no irq when disabled", exp_q.size(), 0);

    // R7 backup flag
    below_bak = 1; wait_cyc(20);
    check(backup_act_n == 0, "R7 backup active", backup_act_n, 0);
    below_bak = 0; wait_cyc(20);
    check(backup_act_n == 1, "R7 backup idle", backup_act_n, 1);

    // below minimum, warning crossing while in reset (R4)
    irq_en = 1;
    expect_ev("RST_ON", "R5", 0, 0);
    below_min = 1; wait_cyc(20);
    check(mem_en_n_out == '1 && wr_n_out == 1, "R5 forced", mem_en_n_out, 4'hF);
    check(stat_pull_low == 1, "R6 pin driven", stat_pull_low, 1);
    below_warn = 1; wait_cyc(20);
    check(pfw_irq == 0, "R4 blocked", pfw_irq, 0);
    expect_ev("RST_OFF", "R10", POR, POR + 24);
    below_min = 0; mark = cyc;
    wait_cyc(POR + 40);
    below_warn = 0; wait_cyc(20);

    // R9 external reset
    expect_ev("RST_ON", "R9", 0, 0);
    ext_reset = 1; wait_cyc(20);
    check(cpu_reset == 1, "R9 ext reset", cpu_reset, 1);
    expect_ev("RST_OFF", "R10", POR, POR + 24);
    ext_reset = 0; mark = cyc;
    wait_cyc(POR + 40);

    // R8 another device pulls the status pin low
    expect_ev("RST_ON", "R8", 0, 0);
    ext_pull = 1; wait_cyc(20);
    check(cpu_reset == 1, "R8 pin forces reset", cpu_reset, 1);
    check(mem_en_n_out == 4'b0101, "R5 pin reset keeps enables", mem_en_n_out, 4'b0101);
    expect_ev("RST_OFF", "R10", POR, POR + 24);
    ext_pull = 0; mark = cyc;
    wait_cyc(POR + 40);

    check(exp_q.size() == 0, "R2 all events seen", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule